// File: doc/BRIEF.md
# Privilege Trap-Control Checker

This block keeps a 32-bit machine-level status word. It decides whether a privileged operation may run at the hart's current privilege level. Three bits of the status word are trap controls. Each one raises the level that a particular operation needs from supervisor to machine. This lets machine-level software intercept supervisor code that tries to fence address translation, read the translation base register, return from a supervisor trap, or stall waiting for an interrupt.

Software updates the status word through a masked write port. A decode stage presents an operation class together with the current privilege level. One cycle later the block answers with either an allow pulse or an illegal-instruction pulse. Decode, TLB maintenance, return sequencing and the actual stall are handled outside the block.

Top module: `trapctl_top`

## Requirements
- R1: After reset the status word reads 0, which clears all three trap-control bits, and both `allow` and `illegal` are low.
- R2: A write with `csrWrEn` high replaces only the writable bits 1, 3, 5, 7, 8, 11, 12, 13, 14, 17, 18, 19, 20, 21 and 22 (mask 0x007E79AA) with the corresponding bits of `csrWrData`. Every other bit keeps its value. The status word does not change in a cycle without a write.
- R3: The extension-state field, bits 16:15, is writable only when parameter `HAS_EXT` is 1. In that case the mask becomes 0x007FF9AA. With the default `HAS_EXT` of 0, writes leave the field at 0.
- R4: Bit 31 is a read-only summary. It reads 1 exactly when the float-state field (bits 14:13) or the extension-state field (bits 16:15) equals 3. Writing bit 31 has no effect.
- R5: Privilege is encoded as user 0, supervisor 1 and machine 3. An operation passes when `curPriv` is greater than or equal to its required level. The translation fence (`opClass` 0) requires level 3 when bit 20 (trap-VM) is set, and level 1 otherwise.
- R6: The supervisor return (`opClass` 1) requires level 3 when bit 22 (trap-return) is set, and level 1 otherwise.
- R7: The wait-for-interrupt operation (`opClass` 2) requires level 3 when bit 21 (wait-trap) is set, and level 1 otherwise.
- R8: A read of the translation base register (`opClass` 3) requires level 3 when bit 20 is set, and level 1 otherwise.
- R9: A request (`opValid` high) produces a result in the next cycle. That result is either `allow` high or `illegal` high, never both, and it lasts exactly one cycle. Without a request in the previous cycle, both outputs are low.
- R10: A request that arrives in the same cycle as a status write is judged against the status value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Status word write enable |
| csrWrData | input | 32 | Status word write data |
| opValid | input | 1 | A privileged operation is being checked this cycle |
| opClass | input | 2 | 0 fence, 1 supervisor return, 2 wait, 3 base register read |
| curPriv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| statusOut | output | 32 | Status word including the summary bit |
| allow | output | 1 | Operation permitted (one-cycle pulse) |
| illegal | output | 1 | Illegal-instruction pulse |

## Verification
The checker checks the following on every cycle: that the two result pulses are exclusive and appear only after a request, that non-writable bits stay zero, that the word holds steady without a write, that machine level is always allowed and user level always refused, and that the supervisor return passes when its trap bit is clear. The bench scenarios cover the rest. They walk the full grid of operation, trap bit and privilege level. They show the exact write-mask pattern with and without the extension field, set and clear the summary bit, and confirm that a decision sees the status value from before a same-cycle write.

// File: rtl/trapctl_pkg.sv
package trapctl_pkg;

  localparam int STATUS_W = 32;
  localparam int PRIV_W = 2;

  localparam logic [PRIV_W-1:0] PRIV_USER = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_SUP  = 2'd1;
  localparam logic [PRIV_W-1:0] PRIV_MACH = 2'd3;

  // bit positions software decodes
  localparam int BIT_TRAPVM   = 20;
  localparam int BIT_WAITTRAP = 21;
  localparam int BIT_RETTRAP  = 22;
  localparam int FLT_LO       = 13;
  localparam int EXT_LO       = 15;
  localparam int SUMMARY_BIT  = 31;

  typedef enum logic [1:0] {
    OP_FENCE  = 2'd0,
    OP_RET    = 2'd1,
    OP_WAIT   = 2'd2,
    OP_BASERD = 2'd3
  } opClass_e;

  typedef struct packed {
    logic trapVm;
    logic waitTrap;
    logic retTrap;
  } trapBits_t;

  typedef struct packed {
    logic wrStatus;
    logic decide;
  } ctlStrobe_t;

  // bits software may change
  function automatic logic [STATUS_W-1:0] writeMask(input bit hasExt);
    logic [STATUS_W-1:0] m;
    m = '0;
    m[1] = 1'b1;   // supervisor interrupt enable
    m[3] = 1'b1;   // machine interrupt enable
    m[5] = 1'b1;   // supervisor previous enable
    m[7] = 1'b1;   // machine previous enable
    m[8] = 1'b1;   // supervisor previous level
    m[12:11] = 2'b11; // machine previous level
    m[FLT_LO+1:FLT_LO] = 2'b11;
    m[17] = 1'b1;  // modify-privilege
    m[18] = 1'b1;  // user-page protect
    m[19] = 1'b1;  // make-executable-readable
    m[BIT_TRAPVM] = 1'b1;
    m[BIT_WAITTRAP] = 1'b1;
    m[BIT_RETTRAP] = 1'b1;
    if (hasExt) m[EXT_LO+1:EXT_LO] = 2'b11;
    return m;
  endfunction

endpackage

// File: rtl/trapctl_datapath.sv
module trapctl_datapath
  import trapctl_pkg::*;
#(
  parameter bit HAS_EXT = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [STATUS_W-1:0] wrData,
  output logic [STATUS_W-1:0] statusWord,
  output trapBits_t           trapBits
);

  localparam logic [STATUS_W-1:0] WMASK = writeMask(HAS_EXT);

  logic [STATUS_W-2:0] statusReg;
  logic [STATUS_W-2:0] statusNext;
  logic                dirtySummary;

  always_comb begin
    statusNext = statusReg;
    if (strobe.wrStatus)
      statusNext = (statusReg & ~WMASK[STATUS_W-2:0]) | (wrData[STATUS_W-2:0] & WMASK[STATUS_W-2:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) statusReg <= '0;
    else       statusReg <= statusNext;
  end

  always_comb begin
    dirtySummary = (statusReg[FLT_LO+1:FLT_LO] == 2'b11) ||
                   (statusReg[EXT_LO+1:EXT_LO] == 2'b11);
  end

  assign statusWord = {dirtySummary, statusReg};

  assign trapBits.trapVm   = statusReg[BIT_TRAPVM];
  assign trapBits.waitTrap = statusReg[BIT_WAITTRAP];
  assign trapBits.retTrap  = statusReg[BIT_RETTRAP];

endmodule

// File: rtl/trapctl_control.sv
module trapctl_control
  import trapctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csrWrEn,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic [PRIV_W-1:0] curPriv,
  input  trapBits_t         trapBits,
  output ctlStrobe_t        strobe,
  output logic              allow,
  output logic              illegal
);

  opClass_e          opKind;
  logic [PRIV_W-1:0] reqLevel;
  logic              levelOk;
  logic              allowQ;
  logic              illegalQ;

  assign opKind = opClass_e'(opClass);

  always_comb begin
    reqLevel = PRIV_SUP;
    unique case (opKind)
      OP_FENCE:  reqLevel = trapBits.trapVm   ? PRIV_MACH : PRIV_SUP;
      OP_RET:    reqLevel = trapBits.retTrap  ? PRIV_MACH : PRIV_SUP;
      OP_WAIT:   reqLevel = trapBits.waitTrap ? PRIV_MACH : PRIV_SUP;
      OP_BASERD: reqLevel = trapBits.trapVm   ? PRIV_MACH : PRIV_SUP;
      default:   reqLevel = PRIV_MACH;
    endcase
  end

  assign levelOk = (curPriv >= reqLevel);

  always_comb begin
    strobe.wrStatus = csrWrEn;
    strobe.decide   = opValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      allowQ   <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      allowQ   <= strobe.decide && levelOk;
      illegalQ <= strobe.decide && !levelOk;
    end
  end

  assign allow   = allowQ;
  assign illegal = illegalQ;

endmodule

// File: rtl/trapctl_top.sv
module trapctl_top
  import trapctl_pkg::*;
#(
  parameter bit HAS_EXT = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csrWrEn,
  input  logic [31:0] csrWrData,
  input  logic        opValid,
  input  logic [1:0]  opClass,
  input  logic [1:0]  curPriv,
  output logic [31:0] statusOut,
  output logic        allow,
  output logic        illegal
);

  ctlStrobe_t strobe;
  trapBits_t  trapBits;

  trapctl_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .csrWrEn  (csrWrEn),
    .opValid  (opValid),
    .opClass  (opClass),
    .curPriv  (curPriv),
    .trapBits (trapBits),
    .strobe   (strobe),
    .allow    (allow),
    .illegal  (illegal)
  );

  trapctl_datapath #(.HAS_EXT(HAS_EXT)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wrData     (csrWrData),
    .statusWord (statusOut),
    .trapBits   (trapBits)
  );

endmodule

// File: rtl/trapctl_checker.sv
module trapctl_checker
  import trapctl_pkg::*;
#(
  parameter bit HAS_EXT = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic        csrWrEn,
  input logic        opValid,
  input logic [1:0]  opClass,
  input logic [1:0]  curPriv,
  input logic [31:0] statusOut,
  input logic        allow,
  input logic        illegal
);

  localparam logic [31:0] FIXED = ~writeMask(HAS_EXT) & 32'h7FFF_FFFF;

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(allow && illegal));

  a_r9_no_request: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> (!allow && !illegal));

  a_r9_answers: assert property (@(posedge clk) disable iff (!rstN)
    opValid |=> (allow || illegal));

  a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut & FIXED) == 32'h0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !csrWrEn |=> $stable(statusOut));

  // R5 R6 R7 R8: machine level always passes
  a_r5_machine_ok: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && curPriv == PRIV_MACH) |=> allow);

  // R5 R6 R7 R8: user level never passes
  a_r5_user_refused: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && curPriv == PRIV_USER) |=> illegal);

  a_r6_ret_clear: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd1 && curPriv == PRIV_SUP && !statusOut[BIT_RETTRAP]) |=> allow);

endmodule

bind trapctl_top trapctl_checker #(.HAS_EXT(HAS_EXT)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csrWrEn   (csrWrEn),
  .opValid   (opValid),
  .opClass   (opClass),
  .curPriv   (curPriv),
  .statusOut (statusOut),
  .allow     (allow),
  .illegal   (illegal)
);

// File: tb/tb_trapctl_top.sv
`timescale 1ns/1ps
module tb_trapctl_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csrWrEn = 1'b0;
  logic [31:0] csrWrData = '0;
  logic        opValid = 1'b0;
  logic [1:0]  opClass = '0;
  logic [1:0]  curPriv = '0;
  logic [31:0] statusOut, statusExt;
  logic        allow, illegal, allowExt, illegalExt;

  logic        extWrEn = 1'b0;
  logic [31:0] extWrData = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trapctl_top dut (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrWrData(csrWrData),
    .opValid(opValid), .opClass(opClass), .curPriv(curPriv),
    .statusOut(statusOut), .allow(allow), .illegal(illegal)
  );

  trapctl_top #(.HAS_EXT(1'b1)) dutExt (
    .clk(clk), .rstN(rstN), .csrWrEn(extWrEn), .csrWrData(extWrData),
    .opValid(1'b0), .opClass(2'd0), .curPriv(2'd0),
    .statusOut(statusExt), .allow(allowExt), .illegal(illegalExt)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeStatus(input logic [31:0] d);
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = d;
    @(negedge clk);
    csrWrEn = 1'b0;
  endtask

  function automatic logic [1:0] needLevel(input logic [1:0] cls, input logic [31:0] st);
    logic trap;
    case (cls)
      2'd0: trap = st[20];
      2'd1: trap = st[22];
      2'd2: trap = st[21];
      default: trap = st[20];
    endcase
    return trap ? 2'd3 : 2'd1;
  endfunction

  // issue one request, return {allow, illegal} sampled the following cycle
  task automatic request(input logic [1:0] cls, input logic [1:0] pv, output logic [1:0] res);
    @(negedge clk);
    opValid = 1'b1; opClass = cls; curPriv = pv;
    @(negedge clk);
    opValid = 1'b0;
    res = {allow, illegal};
  endtask

  task automatic testReset();
    check("R1 status", statusOut, 32'h0);
    check("R1 allow/illegal", {30'd0, allow, illegal}, 32'h0);
  endtask

  task automatic testMask();
    writeStatus(32'hFFFF_FFFF);
    check("R2 mask all-ones", statusOut, 32'h807E_79AA);
    writeStatus(32'h0);
    check("R2 mask zeros", statusOut, 32'h0);
    writeStatus(32'hFF81_8655);
    check("R2 non-writable only", statusOut, 32'h0);
    writeStatus(32'h0000_0102);
    repeat (3) @(negedge clk);
    check("R2 hold without write", statusOut, 32'h0000_0102);
    writeStatus(32'h0);
  endtask

  task automatic testExt();
    writeStatus(32'h0001_8000);
    check("R3 ext field ignored by default", statusOut, 32'h0);
    @(negedge clk);
    extWrEn = 1'b1; extWrData = 32'hFFFF_FFFF;
    @(negedge clk);
    extWrEn = 1'b0;
    check("R3 ext mask", statusExt, 32'h807F_F9AA);
    @(negedge clk);
    extWrEn = 1'b1; extWrData = 32'h0001_8000;
    @(negedge clk);
    extWrEn = 1'b0;
    check("R4 ext dirty summary", statusExt, 32'h8001_8000);
  endtask

  task automatic testSummary();
    writeStatus(32'h8000_0000);
    check("R4 summary not writable", statusOut, 32'h0);
    writeStatus(32'h0000_6000);
    check("R4 float dirty", statusOut, 32'h8000_6000);
    writeStatus(32'h0000_4000);
    check("R4 float not dirty", statusOut, 32'h0000_4000);
    writeStatus(32'h0);
  endtask

  task automatic testGrid();
    logic [1:0] res;
    logic [1:0] exp;
    string tag;
    for (int trap = 0; trap < 2; trap++) begin
      logic [31:0] st;
      st = trap ? 32'h0070_0000 : 32'h0;
      writeStatus(st);
      for (int c = 0; c < 4; c++) begin
        for (int p = 0; p < 4; p++) begin
          if (p == 2) continue;
          request(c[1:0], p[1:0], res);
          exp = (p[1:0] >= needLevel(c[1:0], st)) ? 2'b10 : 2'b01;
          case (c)
            0: tag = "R5 fence";
            1: tag = "R6 return";
            2: tag = "R7 wait";
            default: tag = "R8 base read";
          endcase
          check(tag, {30'd0, res}, {30'd0, exp});
        end
      end
    end
    // each trap bit acts alone
    writeStatus(32'h0020_0000);
    request(2'd2, 2'd1, res);
    check("R7 wait-trap alone", {30'd0, res}, 32'h1);
    request(2'd0, 2'd1, res);
    check("R5 unaffected by wait-trap", {30'd0, res}, 32'h2);
    writeStatus(32'h0040_0000);
    request(2'd1, 2'd1, res);
    check("R6 return-trap alone", {30'd0, res}, 32'h1);
    request(2'd3, 2'd1, res);
    check("R8 unaffected by return-trap", {30'd0, res}, 32'h2);
    writeStatus(32'h0);
  endtask

  task automatic testTiming();
    @(negedge clk);
    opValid = 1'b1; opClass = 2'd0; curPriv = 2'd1;
    @(negedge clk);
    opValid = 1'b0;
    check("R9 pulse cycle", {30'd0, allow, illegal}, 32'h2);
    @(negedge clk);
    check("R9 one cycle only", {30'd0, allow, illegal}, 32'h0);
  endtask

  task automatic testSameCycle();
    @(negedge clk);
    csrWrEn = 1'b1; csrWrData = 32'h0010_0000;
    opValid = 1'b1; opClass = 2'd0; curPriv = 2'd1;
    @(negedge clk);
    csrWrEn = 1'b0; opValid = 1'b0;
    check("R10 old status used", {30'd0, allow, illegal}, 32'h2);
    check("R10 write landed", statusOut, 32'h0010_0000);
    @(negedge clk);
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check("R10 new status next", {30'd0, allow, illegal}, 32'h1);
    writeStatus(32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMask();
    testExt();
    testSummary();
    testGrid();
    testTiming();
    testSameCycle();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule